// File: doc/BRIEF.md
# Controller Port Bus Interface

This block sits on an 8-bit CPU bus and serves two serial game-controller ports. A CPU write to the output address stores the low three data bits in an output latch. Bit 0 of that latch is the level that tells both controllers to load their button states in parallel. A CPU read of either port address drives that port's clock low for as long as the read lasts. The falling edge of the port clock captures the inverted serial line, and the rising edge makes the controller shift out its next bit.

The returned byte carries the captured serial bit in bit 0 and zeros in bits 4 to 1. The upper three bits are not driven by the port, so they repeat the last byte seen on the bus. That byte is tracked one bus cycle at a time. In a normal absolute-address read, the last byte seen is the address high byte, so the result is 0x40 or 0x41. Every clock cycle is one bus cycle, and the port clocks follow the bus combinationally. A bus cycle that leaves the port address for one cycle in the middle of a read therefore produces an extra clock rise. The controller then drops a bit, and the interface makes this hazard observable.

Top module: `ctrl_port_if`

## Requirements
- R1: A cycle with `cpu_rw`=0 at address `BASE_ADDR` (0x4016) loads `cpu_wdata[2:0]` into `out_bits` at the clock edge that ends the cycle. Bit 0 of `out_bits` is the load level for both controllers and holds until the next such write.
- R2: Port i uses address `BASE_ADDR`+i: port 0 is 0x4016 and port 1 is 0x4017. `port_clk_n[i]` is low exactly in the cycles with `cpu_rw`=1 at that address and is high in every other cycle. Reading one port therefore never lowers the other port's clock.
- R3: In the first cycle of a low period of `port_clk_n[i]`, bit 0 of the read byte is the inverse of `ser_in[i]`. That bit is held until the next falling edge of the same port clock.
- R4: In a port read cycle, bits 4 to 1 of `rd_data` are 0 and bits 7 to 5 equal bits 7 to 5 of the last bus byte.
- R5: The last bus byte is updated at every clock edge. A write cycle stores `cpu_wdata`, a port read stores the byte returned, and any other read stores `bus_in`. As a result, a port read that follows a read returning 0x40 yields 0x40 or 0x41.
- R6: A serial line held high, meaning nothing is connected and the line is pulled up, reads as 0 in bit 0.
- R7: If a port read is followed by one read cycle at another address and then by a read of the same port again, the port clock rises in between. The second low period returns the next serial bit, so one bit is lost to a reader that treats both low periods as a single read.
- R8: Synchronous reset clears `out_bits`, the last bus byte and the captured bits to 0. `rd_data` is 0 in every cycle that is not a port read.
- R9: A write to any address other than `BASE_ADDR`, including the port 1 address, leaves `out_bits` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; one bus cycle per clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_addr | input | ADDR_W (16) | Bus address of the current cycle |
| cpu_rw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpu_wdata | input | 8 | Data written by the CPU |
| bus_in | input | 8 | Byte placed on the bus by other responders during reads |
| ser_in | input | NPORTS (2) | Serial data line from each controller, active low |
| port_clk_n | output | NPORTS (2) | Per-port clock, low while that port is read |
| out_bits | output | OUT_BITS (3) | Output latch; bit 0 is the controller load level |
| rd_data | output | 8 | Byte returned for a port read, 0 otherwise |

## Verification
The assertions assume that every cycle is a valid bus cycle, with the address and read/write level stable from one clock edge to the next. They also assume that the serial lines change only at clock edges. The bench meets these assumptions by driving every input, including both serial lines from its controller models, from time zero. It changes bus inputs only at falling clock edges and updates the controller shift registers with nonblocking assignments at rising edges. No port is read while reset is asserted, so the first falling edge of a port clock always comes after reset.

// File: rtl/cpi_pkg.sv
package cpi_pkg;

    localparam int DATA_W     = 8;
    localparam int FLOAT_LSB  = 5;   // bits at and above this index float
    localparam int SERIAL_BIT = 0;

    typedef logic [DATA_W-1:0] byte_t;

    typedef enum logic [1:0] {
        CYC_WRITE      = 2'd0,
        CYC_PORT_READ  = 2'd1,
        CYC_OTHER_READ = 2'd2
    } cyc_kind_t;

    // Port read byte: floating top bits from the previous bus byte,
    // zeros in the middle, captured serial bit at the bottom.
    function automatic byte_t form_port_byte(input byte_t prev, input logic dbit);
        byte_t b;
        b = '0;
        b[DATA_W-1:FLOAT_LSB] = prev[DATA_W-1:FLOAT_LSB];
        b[SERIAL_BIT]         = dbit;
        return b;
    endfunction

endpackage

// File: rtl/cpi_out_latch.sv
module cpi_out_latch #(
    parameter int OUT_BITS = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_hit,
    input  logic [OUT_BITS-1:0] wbits,
    output logic [OUT_BITS-1:0] out_q
);
    always_ff @(posedge clk) begin
        if (rst)         out_q <= '0;
        else if (wr_hit) out_q <= wbits;
    end

    assert_latch_load_R1: assert property (@(posedge clk) disable iff (rst)
        wr_hit |=> out_q == $past(wbits));

    assert_latch_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !wr_hit |=> $stable(out_q));
endmodule

// File: rtl/cpi_port_lane.sv
module cpi_port_lane (
    input  logic clk,
    input  logic rst,
    input  logic rd_en,
    input  logic addr_match,
    input  logic ser_in,
    output logic clk_n,
    output logic dbit
);
    logic prev_q;
    logic cap_q;
    logic fall;

    assign clk_n = ~(rd_en & addr_match);
    assign fall  = prev_q & ~clk_n;
    assign dbit  = fall ? ~ser_in : cap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b1;
            cap_q  <= 1'b0;
        end else begin
            prev_q <= clk_n;
            if (fall) cap_q <= ~ser_in;
        end
    end

    assert_capture_on_fall_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(clk_n) |=> cap_q == ~$past(ser_in));

    assert_held_while_low_R3: assert property (@(posedge clk) disable iff (rst)
        (!clk_n && $past(!clk_n)) |-> dbit == cap_q);
endmodule

// File: rtl/cpi_open_bus.sv
module cpi_open_bus
    import cpi_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  cyc_kind_t kind,
    input  byte_t     wdata,
    input  byte_t     port_byte,
    input  byte_t     bus_in,
    output byte_t     last_q
);
    byte_t next_b;

    always_comb begin
        unique case (kind)
            CYC_WRITE:     next_b = wdata;
            CYC_PORT_READ: next_b = port_byte;
            default:       next_b = bus_in;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) last_q <= '0;
        else     last_q <= next_b;
    end

    assert_tracks_write_R5: assert property (@(posedge clk) disable iff (rst)
        kind == CYC_WRITE |=> last_q == $past(wdata));

    assert_tracks_port_R5: assert property (@(posedge clk) disable iff (rst)
        kind == CYC_PORT_READ |=> last_q == $past(port_byte));
endmodule

// File: rtl/ctrl_port_if.sv
module ctrl_port_if
    import cpi_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter int              NPORTS    = 2,
    parameter int              OUT_BITS  = 3,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4016
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [ADDR_W-1:0]   cpu_addr,
    input  logic                cpu_rw,
    input  logic [DATA_W-1:0]   cpu_wdata,
    input  logic [DATA_W-1:0]   bus_in,
    input  logic [NPORTS-1:0]   ser_in,
    output logic [NPORTS-1:0]   port_clk_n,
    output logic [OUT_BITS-1:0] out_bits,
    output logic [DATA_W-1:0]   rd_data
);
    logic [NPORTS-1:0] match;
    logic [NPORTS-1:0] rd_hit;
    logic [NPORTS-1:0] dbit;
    logic              wr_hit;
    logic              any_rd;
    byte_t             last_b;
    byte_t             port_b;
    cyc_kind_t         kind;

    assign wr_hit = ~cpu_rw & (cpu_addr == BASE_ADDR);

    cpi_out_latch #(.OUT_BITS(OUT_BITS)) u_latch (
        .clk    (clk),
        .rst    (rst),
        .wr_hit (wr_hit),
        .wbits  (cpu_wdata[OUT_BITS-1:0]),
        .out_q  (out_bits)
    );

    for (genvar gi = 0; gi < NPORTS; gi++) begin : g_lane
        localparam logic [ADDR_W-1:0] LANE_ADDR = BASE_ADDR + ADDR_W'(gi);
        assign match[gi]  = (cpu_addr == LANE_ADDR);
        assign rd_hit[gi] = cpu_rw & match[gi];

        cpi_port_lane u_lane (
            .clk        (clk),
            .rst        (rst),
            .rd_en      (cpu_rw),
            .addr_match (match[gi]),
            .ser_in     (ser_in[gi]),
            .clk_n      (port_clk_n[gi]),
            .dbit       (dbit[gi])
        );
    end

    assign any_rd = |rd_hit;

    always_comb begin
        port_b = '0;
        for (int i = 0; i < NPORTS; i++) begin
            if (rd_hit[i]) port_b = port_b | form_port_byte(last_b, dbit[i]);
        end
    end

    always_comb begin
        if (!cpu_rw)     kind = CYC_WRITE;
        else if (any_rd) kind = CYC_PORT_READ;
        else             kind = CYC_OTHER_READ;
    end

    cpi_open_bus u_bus (
        .clk       (clk),
        .rst       (rst),
        .kind      (kind),
        .wdata     (cpu_wdata),
        .port_byte (port_b),
        .bus_in    (bus_in),
        .last_q    (last_b)
    );

    assign rd_data = port_b;

    assert_one_port_clock_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~port_clk_n));

    assert_write_keeps_clocks_high_R2: assert property (@(posedge clk) disable iff (rst)
        !cpu_rw |-> (&port_clk_n));

    assert_byte_layout_R4: assert property (@(posedge clk) disable iff (rst)
        (!(&port_clk_n)) |-> (rd_data[FLOAT_LSB-1:1] == '0 &&
                              rd_data[DATA_W-1:FLOAT_LSB] == last_b[DATA_W-1:FLOAT_LSB]));

    assert_quiet_outside_read_R8: assert property (@(posedge clk) disable iff (rst)
        (&port_clk_n) |-> rd_data == '0);
endmodule

// File: tb/sim_ctrl_port_if.sv
`timescale 1ns/1ps
module sim_ctrl_port_if;
    localparam real HALF_NS = 2.5;
    localparam int  WD_CYCLES = 200000;
    localparam logic [15:0] P0 = 16'h4016;
    localparam logic [15:0] P1 = 16'h4017;
    localparam logic [15:0] FETCH = 16'h8000;

    // {port1 connected, port1 buttons, port0 buttons}; buttons bit0 = first bit out
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 8'h00, 8'hFF},
        {1'b1, 8'hA5, 8'h5A},
        {1'b0, 8'h3C, 8'h81},
        {1'b1, 8'h01, 8'h80},
        {1'b0, 8'hFF, 8'h00},
        {1'b1, 8'h96, 8'h69}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] cpu_addr = '0;
    logic        cpu_rw = 1'b1;
    logic [7:0]  cpu_wdata = '0;
    logic [7:0]  bus_in = '0;
    logic [1:0]  ser_in;
    logic [1:0]  port_clk_n;
    logic [2:0]  out_bits;
    logic [7:0]  rd_data;

    logic [1:0][7:0] sr = '0;
    logic [1:0][7:0] btn = '0;
    logic [1:0]      conn = 2'b11;
    logic [1:0]      snap_clk = 2'b11;
    logic            snap_stb = 1'b0;
    logic [1:0]      mprev = 2'b11;
    logic [7:0]      got;
    logic [1:0]      got_clk;

    int n_total = 0;
    int n_pass  = 0;
    bit done    = 0;

    always #(HALF_NS) clk = ~clk;

    ctrl_port_if u0 (
        .clk(clk), .rst(rst), .cpu_addr(cpu_addr), .cpu_rw(cpu_rw),
        .cpu_wdata(cpu_wdata), .bus_in(bus_in), .ser_in(ser_in),
        .port_clk_n(port_clk_n), .out_bits(out_bits), .rd_data(rd_data)
    );

    // controller models: active-low line, zero fill, shift on clock rise
    always_comb begin
        for (int i = 0; i < 2; i++) ser_in[i] = conn[i] ? sr[i][0] : 1'b1;
    end

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            if (snap_stb)                     sr[i] <= ~btn[i];
            else if (!mprev[i] && snap_clk[i]) sr[i] <= sr[i] >> 1;
            mprev[i] <= snap_clk[i];
        end
    end

    task automatic bus(input logic [15:0] a, input logic rw, input logic [7:0] wd, input logic [7:0] bi);
        @(negedge clk);
        cpu_addr = a; cpu_rw = rw; cpu_wdata = wd; bus_in = bi;
        #1;
        snap_clk = port_clk_n;
        snap_stb = out_bits[0];
        got      = rd_data;
        got_clk  = port_clk_n;
    endtask

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_total++;
        if (act === exp) n_pass++;
        else $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    endtask

    function automatic logic exp_bit(input logic [7:0] b, input logic c, input int k);
        if (!c) return 1'b0;
        if (k < 8) return b[k];
        return 1'b1;
    endfunction

    task automatic strobe_pulse();
        bus(P0, 1'b0, 8'h01, 8'h00);
        bus(P0, 1'b0, 8'h00, 8'h00);
    endtask

    initial begin
        #(WD_CYCLES * 2 * HALF_NS);
        if (!done) begin
            n_total++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_pass, n_total);
            $finish;
        end
    end

    initial begin
        repeat (3) bus(16'h0000, 1'b1, 8'h00, 8'h00);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R8: reset state
        check("R8 out_bits after reset", {5'b0, out_bits}, 8'h00);
        check("R8 rd_data idle", rd_data, 8'h00);
        check("R2 clocks idle", {6'b0, port_clk_n}, 8'h03);
        // R8/R5: first port read after reset sees a cleared bus byte; model line low -> 1
        bus(P0, 1'b1, 8'h00, 8'h00);
        check("R8 first read after reset", got, 8'h01);
        check("R2 port0 read lowers only port0", {6'b0, got_clk}, 8'h02);

        // R1 / R9: latch writes
        bus(P0, 1'b0, 8'hFE, 8'h00);
        bus(FETCH, 1'b1, 8'h00, 8'h40);
        check("R1 latch low bits", {5'b0, out_bits}, 8'h06);
        check("R8 rd_data zero on fetch", got, 8'h00);
        bus(P1, 1'b0, 8'h07, 8'h00);
        bus(FETCH, 1'b1, 8'h00, 8'h40);
        check("R9 write to port1 address ignored", {5'b0, out_bits}, 8'h06);
        bus(16'h2000, 1'b0, 8'h01, 8'h00);
        bus(FETCH, 1'b1, 8'h00, 8'h40);
        check("R9 write to other address ignored", {5'b0, out_bits}, 8'h06);

        // R1: load level held high -> every read returns first button
        btn[0] = 8'b0000_0010;
        bus(P0, 1'b0, 8'h05, 8'h00);
        for (int k = 0; k < 3; k++) begin
            bus(FETCH, 1'b1, 8'h00, 8'h40);
            bus(P0, 1'b1, 8'h00, 8'h00);
            check("R1 load level held repeats first bit", got, 8'h40);
        end
        check("R1 load bit set", {5'b0, out_bits}, 8'h05);

        // R5: port read straight after a write floats the written byte
        bus(P0, 1'b0, 8'hA0, 8'h00);
        bus(P0, 1'b1, 8'h00, 8'h00);
        check("R5 float from written byte", got, 8'hA0);
        bus(FETCH, 1'b1, 8'h00, 8'h40);
        bus(P0, 1'b1, 8'h00, 8'h00);
        check("R4 byte after 0x40 fetch", got, 8'h41);

        // R7: address leaves the port for one cycle mid-read
        btn[0] = 8'b0000_0101;
        strobe_pulse();
        bus(FETCH, 1'b1, 8'h00, 8'h40);
        bus(P0, 1'b1, 8'h00, 8'h00);
        check("R7 first low period", got, 8'h41);
        bus(16'h4015, 1'b1, 8'h00, 8'hE0);
        check("R7 clock rises in deviating cycle", {6'b0, got_clk}, 8'h03);
        bus(P0, 1'b1, 8'h00, 8'h00);
        check("R7 second low period gives next bit (R5 float E0)", got, 8'hE0);
        bus(FETCH, 1'b1, 8'h00, 8'h40);
        bus(P0, 1'b1, 8'h00, 8'h00);
        check("R7 following read is third bit", got, 8'h41);

        // R3 / R6 / R2: table of button patterns over both ports
        foreach (VEC[v]) begin
            btn[0]  = VEC[v][7:0];
            btn[1]  = VEC[v][15:8];
            conn[1] = VEC[v][16];
            strobe_pulse();
            for (int k = 0; k < 10; k++) begin
                bus(FETCH, 1'b1, 8'h00, 8'h40);
                bus(P0, 1'b1, 8'h00, 8'h00);
                check("R3 port0 serial bit", got, {7'h20, exp_bit(btn[0], 1'b1, k)});
            end
            for (int k = 0; k < 10; k++) begin
                bus(FETCH, 1'b1, 8'h00, 8'h40);
                bus(P1, 1'b1, 8'h00, 8'h00);
                if (conn[1]) check("R3 port1 serial bit, untouched by port0 reads (R2)",
                                   got, {7'h20, exp_bit(btn[1], 1'b1, k)});
                else         check("R6 unconnected port1 reads 0",
                                   got, {7'h20, exp_bit(btn[1], 1'b0, k)});
            end
            check("R2 port1 read lowers only port1", {6'b0, got_clk}, 8'h01);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_pass, n_total);
        $finish;
    end
endmodule